// File: doc/BRIEF.md
# Cached Page Permission Checker

This block stands on the path from an untrusted accelerator's physically addressed caches to the trusted memory system. It sees each outgoing read or write request and decides whether it may go on. Every 4 KB physical page has two permission bits, one for read and one for write, and there is no execute bit. The bits live in a flat table in main memory. The table starts at a base address and is indexed directly by physical page number. A bounds value gives the number of pages of physical memory. Any page number at or above it is refused before the table is consulted.

The permission bits of a run of consecutive pages form one table block, which is fetched as a single memory read. A small fully associative cache holds recently used blocks. Each entry is tagged by the page-number group it covers. Only this block fills the cache, so the cache needs no coherence. Entries are never modified on this path, so an eviction needs no writeback. A request that passes is forwarded one cycle after its decision. A request that fails is dropped, with no data returned and no write performed. A sticky violation flag is then raised for system software and stays set until a configuration write clears it.

Requests use a valid/ready handshake. At most one table fetch is outstanding, and no new request is accepted until it returns.

Top module: `perm_gate`

## Requirements
- R1: After reset, req_ready is 1, fwd_valid, blk_valid, viol and fetch_req are 0, and every cache entry is invalid.
- R2: A request whose page number (address bits above PAGE_SHIFT) is greater than or equal to the bounds value is blocked without any table fetch.
- R3: On a cache miss, fetch_req pulses for one cycle with fetch_addr = base + group × block bytes, where group = page number / PAGES_PER_BLK and block bytes = PAGES_PER_BLK/4. req_ready stays 0 until fill_valid returns.
- R4: In a table block, page offset o (page number mod PAGES_PER_BLK) has its read bit at position 2·o and its write bit at position 2·o+1.
- R5: A read (req_write = 0) passes only if its page's read bit is 1. A passing request appears on fwd_valid with the same address and write flag.
- R6: A write or writeback (req_write = 1) passes only if its page's write bit is 1.
- R7: A failing request never asserts fwd_valid. It produces one blk_valid pulse instead and sets viol.
- R8: viol stays 1 until a configuration write with cfg_sel = 2 and clears the cycle after that write.
- R9: On a cache hit, the decision (fwd_valid or blk_valid) appears in the cycle after the request is accepted, and no fetch is issued.
- R10: Replacement is round-robin over the entries. When all entries are full, the next miss evicts the entry filled earliest.
- R11: Writing the base register (cfg_sel = 0) invalidates every entry and restarts the replacement pointer at entry 0. The bounds value is written with cfg_sel = 1, as a page count.
- R12: A fill_valid pulse with no fetch outstanding is ignored and leaves the cache unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | 0 table base, 1 bounds (pages), 2 clear violation |
| cfg_wdata | input | ADDR_W | Configuration write data |
| req_valid | input | 1 | Accelerator request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_addr | input | ADDR_W | Request physical byte address |
| req_write | input | 1 | 1 for write or writeback, 0 for read |
| fwd_valid | output | 1 | Forwarded request pulse toward memory |
| fwd_addr | output | ADDR_W | Forwarded address |
| fwd_write | output | 1 | Forwarded write flag |
| blk_valid | output | 1 | Pulse marking a dropped request |
| viol | output | 1 | Sticky violation flag |
| fetch_req | output | 1 | Table block fetch pulse |
| fetch_addr | output | ADDR_W | Byte address of the table block |
| fill_valid | input | 1 | Table block return strobe |
| fill_data | input | 2*PAGES_PER_BLK | Returned table block |

## Verification
The bench builds the block with a 32-bit address, 8 pages per table block (two-byte blocks) and 4 cache entries. The small entry count lets five distinct groups reach round-robin eviction in a short run. It also lets the earliest-filled group be evicted and fetched again while a later group still hits. The 64-page bounds value puts the bounds edge one page from a valid table group, so both sides of the limit are exercised.

// File: rtl/perm_pkg.sv
package perm_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } gate_st_e;

    localparam logic [1:0] CFG_BASE  = 2'd0;
    localparam logic [1:0] CFG_BOUND = 2'd1;
    localparam logic [1:0] CFG_CLR   = 2'd2;
endpackage

// File: rtl/perm_bitsel.sv
module perm_bitsel #(
    parameter int OFF_W = 9,
    localparam int BLK_W = 2 << OFF_W
) (
    input  logic [BLK_W-1:0] blk,
    input  logic [OFF_W-1:0] off,
    input  logic             is_write,
    output logic             allow
);
    logic [OFF_W:0] pos;

    always_comb begin
        pos   = {off, is_write};
        allow = blk[pos];
    end
endmodule

// File: rtl/perm_store.sv
module perm_store #(
    parameter int ENTRIES = 64,
    parameter int TAG_W   = 19,
    parameter int BLK_W   = 1024,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inv,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             lk_hit,
    output logic [BLK_W-1:0] lk_data,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [BLK_W-1:0] wr_data
);
    typedef struct packed {
        logic [ENTRIES-1:0]            vld;
        logic [ENTRIES-1:0][TAG_W-1:0] tag;
    } dir_t;

    dir_t               dir_d, dir_q;
    logic [BLK_W-1:0]   data_q [ENTRIES];
    logic [ENTRIES-1:0] hit_vec;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
        assign hit_vec[i] = dir_q.vld[i] && (dir_q.tag[i] == lk_tag);
    end

    always_comb begin
        lk_hit  = |hit_vec;
        lk_data = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (hit_vec[i]) lk_data = lk_data | data_q[i];
        end
    end

    always_comb begin
        dir_d = dir_q;
        if (inv) begin
            dir_d.vld = '0;
        end else if (wr_en) begin
            dir_d.vld[wr_idx] = 1'b1;
            dir_d.tag[wr_idx] = wr_tag;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dir_q <= '0;
        else        dir_q <= dir_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en && !inv) data_q[wr_idx] <= wr_data;
    end

    // R10
    hit_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));
endmodule

// File: rtl/perm_gate.sv
module perm_gate #(
    parameter int ADDR_W        = 40,
    parameter int PAGE_SHIFT    = 12,
    parameter int PAGES_PER_BLK = 512,
    parameter int ENTRIES       = 64,
    localparam int PPN_W     = ADDR_W - PAGE_SHIFT,
    localparam int OFF_W     = $clog2(PAGES_PER_BLK),
    localparam int TAG_W     = PPN_W - OFF_W,
    localparam int BLK_W     = 2 * PAGES_PER_BLK,
    localparam int BLK_BYTES = BLK_W / 8,
    localparam int IDX_W     = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    output logic              fwd_valid,
    output logic [ADDR_W-1:0] fwd_addr,
    output logic              fwd_write,
    output logic              blk_valid,
    output logic              viol,
    output logic              fetch_req,
    output logic [ADDR_W-1:0] fetch_addr,
    input  logic              fill_valid,
    input  logic [BLK_W-1:0]  fill_data
);
    import perm_pkg::*;

    typedef struct packed {
        gate_st_e          st;
        logic [ADDR_W-1:0] base;
        logic [PPN_W:0]    bound;
        logic [ADDR_W-1:0] addr;
        logic              wr;
        logic [IDX_W-1:0]  rr;
        logic              fwd;
        logic              blk;
        logic              viol;
        logic              fetch;
        logic [ADDR_W-1:0] faddr;
    } gate_t;

    gate_t            d, q;
    logic             inv;
    logic             st_wr_en;
    logic             lk_hit;
    logic [BLK_W-1:0] lk_data;
    logic [BLK_W-1:0] sel_blk;
    logic [OFF_W-1:0] sel_off;
    logic             sel_wr;
    logic             allow;
    logic [PPN_W-1:0] req_ppn;
    logic [TAG_W-1:0] req_tag;
    logic [TAG_W-1:0] pend_tag;
    logic             in_bounds;

    assign req_ppn  = req_addr[PAGE_SHIFT +: PPN_W];
    assign req_tag  = req_addr[PAGE_SHIFT + OFF_W +: TAG_W];
    assign pend_tag = q.addr[PAGE_SHIFT + OFF_W +: TAG_W];

    perm_store #(
        .ENTRIES (ENTRIES),
        .TAG_W   (TAG_W),
        .BLK_W   (BLK_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .inv     (inv),
        .lk_tag  (req_tag),
        .lk_hit  (lk_hit),
        .lk_data (lk_data),
        .wr_en   (st_wr_en),
        .wr_idx  (q.rr),
        .wr_tag  (pend_tag),
        .wr_data (fill_data)
    );

    always_comb begin
        if (q.st == ST_WAIT) begin
            sel_blk = fill_data;
            sel_off = q.addr[PAGE_SHIFT +: OFF_W];
            sel_wr  = q.wr;
        end else begin
            sel_blk = lk_data;
            sel_off = req_addr[PAGE_SHIFT +: OFF_W];
            sel_wr  = req_write;
        end
    end

    perm_bitsel #(.OFF_W(OFF_W)) u_bitsel (
        .blk      (sel_blk),
        .off      (sel_off),
        .is_write (sel_wr),
        .allow    (allow)
    );

    always_comb begin
        d         = q;
        d.fwd     = 1'b0;
        d.blk     = 1'b0;
        d.fetch   = 1'b0;
        inv       = 1'b0;
        st_wr_en  = 1'b0;
        in_bounds = ({1'b0, req_ppn} < q.bound);
        req_ready = (q.st == ST_IDLE);

        if (cfg_we) begin
            case (cfg_sel)
                CFG_BASE: begin
                    d.base = cfg_wdata;
                    d.rr   = '0;
                    inv    = 1'b1;
                end
                CFG_BOUND: d.bound = cfg_wdata[PPN_W:0];
                CFG_CLR:   d.viol  = 1'b0;
                default:   ;
            endcase
        end

        if (q.st == ST_IDLE) begin
            if (req_valid) begin
                d.addr = req_addr;
                d.wr   = req_write;
                if (!in_bounds) begin
                    d.blk  = 1'b1;
                    d.viol = 1'b1;
                end else if (lk_hit) begin
                    d.fwd = allow;
                    d.blk = !allow;
                    if (!allow) d.viol = 1'b1;
                end else begin
                    d.st    = ST_WAIT;
                    d.fetch = 1'b1;
                    d.faddr = q.base + ADDR_W'(req_tag) * ADDR_W'(BLK_BYTES);
                end
            end
        end else if (fill_valid) begin
            st_wr_en = 1'b1;
            d.rr     = (q.rr == IDX_W'(ENTRIES - 1)) ? '0 : q.rr + 1'b1;
            d.st     = ST_IDLE;
            d.fwd    = allow;
            d.blk    = !allow;
            if (!allow) d.viol = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) d_reset: q <= '{st: ST_IDLE, default: '0};
        else        q <= d;
    end

    assign fwd_valid  = q.fwd;
    assign fwd_addr   = q.addr;
    assign fwd_write  = q.wr;
    assign blk_valid  = q.blk;
    assign viol       = q.viol;
    assign fetch_req  = q.fetch;
    assign fetch_addr = q.faddr;

    // R3
    fetch_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req |=> !fetch_req);

    // R3
    fetch_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && !fill_valid) |=> !req_ready);

    // R2
    fwd_bounds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid |-> ({1'b0, fwd_addr[PAGE_SHIFT +: PPN_W]} < q.bound));

    // R7
    blk_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blk_valid |-> (!fwd_valid && viol));
endmodule

// File: tb/tb_perm_gate.sv
module tb_perm_gate;
    localparam int AW  = 32;
    localparam int PS  = 12;
    localparam int PPB = 8;
    localparam int ENT = 4;
    localparam int BW  = 2 * PPB;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_sel = '0;
    logic [AW-1:0] cfg_wdata = '0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic          req_write = 1'b0;
    logic          fwd_valid;
    logic [AW-1:0] fwd_addr;
    logic          fwd_write;
    logic          blk_valid;
    logic          viol;
    logic          fetch_req;
    logic [AW-1:0] fetch_addr;
    logic          fill_valid = 1'b0;
    logic [BW-1:0] fill_data = '0;

    perm_gate #(.ADDR_W(AW), .PAGE_SHIFT(PS), .PAGES_PER_BLK(PPB), .ENTRIES(ENT)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_write(req_write),
        .fwd_valid(fwd_valid), .fwd_addr(fwd_addr), .fwd_write(fwd_write),
        .blk_valid(blk_valid), .viol(viol), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
        .fill_valid(fill_valid), .fill_data(fill_data)
    );

    always #5 clk = ~clk;

    typedef struct {
        logic [AW-1:0] addr;
        logic          wr;
        logic          pass;
        string         tag;
    } exp_t;

    exp_t          sb[$];
    int            checks = 0;
    int            fails = 0;
    int            cyc = 0;
    int            dec_cnt = 0;
    int            dec_cyc = 0;
    int            fetch_cnt = 0;
    logic [AW-1:0] last_faddr = '0;
    logic [AW-1:0] cur_base = '0;
    int            cur_bound = 0;
    bit            stray_req = 1'b0;
    bit            finished = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [1:0] rw_of(logic [AW-1:0] blkaddr, int off);
        logic [7:0] h;
        h = 8'(blkaddr >> 1) * 8'd5 + 8'(off * 3);
        return h[2:1];
    endfunction

    function automatic logic [BW-1:0] build_blk(logic [AW-1:0] fa);
        logic [BW-1:0] b;
        logic [1:0]    rw;
        b = '0;
        for (int o = 0; o < PPB; o++) begin
            rw         = rw_of(fa, o);
            b[2*o]     = rw[0];
            b[2*o + 1] = rw[1];
        end
        return b;
    endfunction

    task automatic check(bit ok, string tag, string what, longint act, longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
        end
    endtask

    // Table memory model
    initial begin
        logic [AW-1:0] fa;
        forever begin
            @(negedge clk);
            if (stray_req) begin
                fill_data  = '1;
                fill_valid = 1'b1;
                @(negedge clk);
                fill_valid = 1'b0;
                stray_req  = 1'b0;
            end else if (fetch_req) begin
                fa         = fetch_addr;
                last_faddr = fa;
                fetch_cnt++;
                repeat (3) @(negedge clk);
                fill_data  = build_blk(fa);
                fill_valid = 1'b1;
                @(negedge clk);
                fill_valid = 1'b0;
            end
        end
    end

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && (fwd_valid || blk_valid)) begin
            exp_t e;
            if (sb.size() == 0) begin
                check(1'b0, "R7", "unexpected decision", fwd_valid, 0);
            end else begin
                e = sb.pop_front();
                check(fwd_valid == e.pass, e.tag, "pass", fwd_valid, e.pass);
                check(blk_valid == !e.pass, e.tag, "block", blk_valid, !e.pass);
                if (e.pass) begin
                    check(fwd_addr == e.addr, e.tag, "fwd_addr", fwd_addr, e.addr);
                    check(fwd_write == e.wr, e.tag, "fwd_write", fwd_write, e.wr);
                end else begin
                    check(viol == 1'b1, e.tag, "viol set", viol, 1);
                end
            end
            dec_cnt = dec_cnt + 1;
            dec_cyc = cyc;
        end
    end

    task automatic cfg_write(logic [1:0] sel, logic [AW-1:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
        if (sel == 2'd0) cur_base = data;
        if (sel == 2'd1) cur_bound = int'(data);
    endtask

    task automatic do_req(int ppn, bit wr, bit exp_fetch, string tag);
        exp_t          e;
        logic [1:0]    rw;
        logic [AW-1:0] blkaddr;
        int            f0, d0, acc;
        blkaddr = cur_base + AW'((ppn / PPB) * (BW / 8));
        rw      = rw_of(blkaddr, ppn % PPB);
        e.addr  = (AW'(ppn) << PS) | AW'(12'h3a8);
        e.wr    = wr;
        e.pass  = (ppn < cur_bound) && (wr ? rw[1] : rw[0]);
        e.tag   = tag;
        sb.push_back(e);
        f0 = fetch_cnt;
        d0 = dec_cnt;
        @(negedge clk);
        req_valid = 1'b1; req_addr = e.addr; req_write = wr;
        while (!req_ready) @(negedge clk);
        acc = cyc;
        @(negedge clk);
        req_valid = 1'b0;
        while (dec_cnt == d0) @(negedge clk);
        check(fetch_cnt - f0 == int'(exp_fetch), tag, "fetch count", fetch_cnt - f0, exp_fetch);
        if (exp_fetch)
            check(last_faddr == blkaddr, tag, "fetch_addr", last_faddr, blkaddr);
        else
            check(dec_cyc == acc + 1, tag, "hit latency", dec_cyc - acc, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(req_ready == 1'b1, "R1", "req_ready", req_ready, 1);
        check(fwd_valid == 1'b0, "R1", "fwd_valid", fwd_valid, 0);
        check(blk_valid == 1'b0, "R1", "blk_valid", blk_valid, 0);
        check(viol == 1'b0, "R1", "viol", viol, 0);
        check(fetch_req == 1'b0, "R1", "fetch_req", fetch_req, 0);

        cfg_write(2'd0, 32'h0000_1000);
        cfg_write(2'd1, 32'd64);

        // R3 first access misses and fetches the group block
        do_req(3, 1'b0, 1'b1, "R3");
        // R4 R5 R6 R9 all offsets of group 0 hit, reads and writes
        for (int p = 0; p < PPB; p++) begin
            do_req(p, 1'b0, 1'b0, "R5");
            do_req(p, 1'b1, 1'b0, "R6");
        end
        do_req(6, 1'b1, 1'b0, "R4");
        do_req(2, 1'b0, 1'b0, "R9");

        // R2 out of bounds blocked without a fetch
        cfg_write(2'd2, '0);
        do_req(64, 1'b0, 1'b0, "R2");
        check(viol == 1'b1, "R7", "viol after block", viol, 1);
        // R8 sticky until cleared
        repeat (3) @(negedge clk);
        check(viol == 1'b1, "R8", "viol held", viol, 1);
        cfg_write(2'd2, '0);
        check(viol == 1'b0, "R8", "viol cleared", viol, 0);
        do_req(63, 1'b1, 1'b1, "R2");

        // R12 stray fill has no effect
        stray_req = 1'b1;
        while (stray_req) @(negedge clk);
        do_req(16, 1'b0, 1'b1, "R12");
        do_req(17, 1'b1, 1'b0, "R12");

        // R11 base write invalidates all entries
        cfg_write(2'd0, 32'h0000_2000);
        do_req(0, 1'b0, 1'b1, "R11");
        // R10 round-robin fill of the remaining entries and eviction
        do_req(8, 1'b0, 1'b1, "R10");
        do_req(16, 1'b1, 1'b1, "R10");
        do_req(24, 1'b0, 1'b1, "R10");
        do_req(32, 1'b1, 1'b1, "R10");
        do_req(9, 1'b1, 1'b0, "R10");
        do_req(1, 1'b0, 1'b1, "R10");

        repeat (4) @(negedge clk);
        check(sb.size() == 0, "R7", "pending decisions", sb.size(), 0);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule